// File: doc/BRIEF.md
# Byte-Indexed Bit Gather Unit

This block gathers single bits out of a data word. It takes two words of the same width. The selector word is split into eight selector bytes. Each selector byte names one bit of the data word, or it names nothing when its value is too large. The bits that the selectors name are packed into one byte at the low end of the result, and every other bit of the result is zero.

All bit and byte positions are counted from the most significant end. Selector byte 0 sits at the top of the selector word. A selector value of 0 names the most significant data bit. The bit picked by selector 0 becomes the highest bit of the result byte. The unit has no clock and no state, so the result follows the operands directly. It is meant to sit inside an execution stage that owns the operand and result registers.

Top module: `bit_gather_unit`

## Requirements
- R1: Selector byte i (i = 0..7) is taken from rs little-endian bits [63-8i : 56-8i], so byte 0 is rs[63:56] and byte 7 is rs[7:0].
- R2: A selector value s in the range 0..63 picks the data bit at big-endian position s, which is rb little-endian bit 63-s.
- R3: A selector value of 64 or more, which means bit 7 or bit 6 of the selector byte is set, yields a zero result bit whatever rb holds.
- R4: Result bits ra[63:8] are zero for every operand pair.
- R5: The bit chosen by selector byte i lands in ra little-endian bit 7-i, so byte 0 drives ra[7] and byte 7 drives ra[0].
- R6: The result is a pure function of the present rs and rb values. It holds no state and settles within the same cycle that the operands change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs | input | 64 | Selector word: eight selector bytes, byte 0 in the top byte |
| rb | input | 64 | Data word that single bits are picked from, big-endian numbering |
| ra | output | 64 | Gathered byte in ra[7:0], upper 56 bits zero |

## Verification
The bench builds the block with its default parameters: a 64-bit data word and 8-bit selectors. That gives eight lanes whose selector space has only 256 values, so every lane is swept through all 256 selector values. Each sweep runs against two complementary data words, while the other lanes hold the out-of-range value 255. This reaches both range boundaries, 63 and 64, in every lane, as well as the extreme values 0 and 255. A walking-one data word paired with equal selectors in all lanes pins down the big-endian bit mapping. A pseudo-random run then mixes in-range and out-of-range selectors across all lanes at once.

// File: rtl/bit_gather_pkg.sv
package bit_gather_pkg;

  // Position counted from the MSB, converted to a little-endian index.
  function automatic int unsigned be_to_le(input int unsigned width,
                                           input int unsigned be_pos);
    return width - 1 - be_pos;
  endfunction

  // A selector names a real bit only when it is below the word width.
  function automatic logic sel_fits(input int unsigned width,
                                    input int unsigned sel);
    return sel < width;
  endfunction

  // Little-endian low bit of big-endian selector slot i.
  function automatic int unsigned slot_lsb(input int unsigned width,
                                           input int unsigned sel_w,
                                           input int unsigned slot);
    return width - sel_w * (slot + 1);
  endfunction

endpackage

// File: rtl/bit_gather_lane.sv
module bit_gather_lane
  import bit_gather_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 8
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] data,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic             over_range;
  logic [IDX_W-1:0] le_idx;

  // Any selector bit at or above IDX_W means the value exceeds the word.
  generate
    if (SEL_W > IDX_W) begin : g_wide
      assign over_range = |sel[SEL_W-1:IDX_W];
    end else begin : g_narrow
      assign over_range = 1'b0;
    end
  endgenerate

  // DATA_W is a power of two, so DATA_W-1-s is the bitwise inverse of s.
  assign le_idx = ~sel[IDX_W-1:0];
  assign bit_o  = over_range ? 1'b0 : data[le_idx];

  // Checks restate the selection arithmetically, away from the mux above.
  logic [IDX_W-1:0] chk_idx;
  logic             chk_fits;
  assign chk_fits = sel_fits(DATA_W, 32'(sel));
  assign chk_idx  = IDX_W'(be_to_le(DATA_W, 32'(sel) % DATA_W));

  always_comb begin
    if (chk_fits) begin
      p_pick_be_bit_r2: assert (bit_o == data[chk_idx]);
    end else begin
      p_zero_out_of_range_r3: assert (bit_o == 1'b0);
    end
  end

endmodule

// File: rtl/bit_gather_pack.sv
module bit_gather_pack #(
  parameter int DATA_W = 64,
  parameter int NSEL   = 8
) (
  input  logic [NSEL-1:0]   perm,
  output logic [DATA_W-1:0] word
);
  // perm[0] goes to the top of the low byte, perm[NSEL-1] to bit 0.
  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_place
      assign word[NSEL-1-i] = perm[i];
    end
  endgenerate

  assign word[DATA_W-1:NSEL] = '0;

  // R4: no bit beyond the packed byte may be set, so the packed word
  // carries exactly as many ones as the lane outputs do.
  always_comb begin
    p_ones_conserved_r4: assert ($countones(word) == $countones(perm));
  end

endmodule

// File: rtl/bit_gather_unit.sv
module bit_gather_unit
  import bit_gather_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 8
) (
  input  logic [DATA_W-1:0] rs,
  input  logic [DATA_W-1:0] rb,
  output logic [DATA_W-1:0] ra
);
  localparam int NSEL = DATA_W / SEL_W;

  logic [NSEL-1:0] perm;

  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_lane
      localparam int LSB = slot_lsb(DATA_W, SEL_W, i);
      bit_gather_lane #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
      ) u_lane (
        .sel   (rs[LSB +: SEL_W]),
        .data  (rb),
        .bit_o (perm[i])
      );
    end
  endgenerate

  bit_gather_pack #(
    .DATA_W (DATA_W),
    .NSEL   (NSEL)
  ) u_pack (
    .perm (perm),
    .word (ra)
  );

  // R1/R5: all-zero selectors must copy the data MSB into every slot.
  always_comb begin
    if (rs == '0) begin
      p_zero_sel_copies_msb_r5: assert (ra[NSEL-1:0] == {NSEL{rb[DATA_W-1]}});
    end
  end

endmodule

// File: tb/bit_gather_unit_test.sv
module bit_gather_unit_test;
  logic        clk = 1'b0;
  logic [63:0] rs, rb;
  logic [63:0] ra;
  int          n_checks = 0;
  int          n_fail   = 0;

  always #4 clk = ~clk;

  bit_gather_unit uut (.rs(rs), .rb(rb), .ra(ra));

  // Reference model: explicit loop over big-endian slots.
  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] d);
    logic [63:0] res = 64'd0;
    for (int i = 0; i < 8; i++) begin
      int unsigned v = int'((s >> (56 - 8 * i)) & 64'hFF);
      logic b = 1'b0;
      if (v < 64) b = d[63 - v];
      res = res | (64'(b) << (7 - i));
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rs=%h rb=%h actual=%h expected=%h", req, rs, rb, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] s, input logic [63:0] d);
    @(negedge clk);
    rs = s;
    rb = d;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    logic [63:0] lfsr;
    rs = '0;
    rb = '0;
    #1;
    // R4 R6: quiescent operands give an all-zero result
    check("R4 idle", ra, 64'd0);

    // R5 R1: selectors 0 pick the MSB into every slot
    apply(64'd0, 64'h8000_0000_0000_0000);
    check("R5 sel0 msb", ra, 64'h0000_0000_0000_00FF);
    // R3: 255 in every slot zeroes even an all-ones data word
    apply({8{8'hFF}}, {64{1'b1}});
    check("R3 all 255", ra, 64'd0);
    // R3: 64 in every slot
    apply({8{8'h40}}, {64{1'b1}});
    check("R3 all 64", ra, 64'd0);
    // R2: 63 in every slot picks the LSB
    apply({8{8'h3F}}, 64'd1);
    check("R2 all 63", ra, 64'h0000_0000_0000_00FF);

    // R2: walking one, equal selectors
    for (int n = 0; n < 64; n++) begin
      apply({8{8'(n)}}, 64'h8000_0000_0000_0000 >> n);
      check("R2 walking one", ra, 64'hFF);
      check("R4 upper zero", ra >> 8, 64'd0);
    end

    // R1 R2 R3 R5: exhaustive per-slot sweep, other slots out of range
    for (int p = 0; p < 2; p++) begin
      pat = (p == 0) ? 64'hA5C3_0F96_1E2D_7B48 : ~64'hA5C3_0F96_1E2D_7B48;
      for (int lane = 0; lane < 8; lane++) begin
        for (int v = 0; v < 256; v++) begin
          logic [63:0] s = {8{8'hFF}};
          s[(56 - 8 * lane) +: 8] = 8'(v);
          apply(s, pat);
          check("R1/R5 slot sweep", ra, model(s, pat));
        end
      end
    end

    // R6: operands changed every cycle, result tracks at once
    lfsr = 64'h1234_5678_9ABC_DEF1;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] s;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      s = lfsr & {8{8'h7F}};
      apply(s, ~lfsr ^ (lfsr << 7));
      check("R6 random", ra, model(s, ~lfsr ^ (lfsr << 7)));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule